// File: doc/BRIEF.md
# Memory Error Event Router

This block sits beside a DRAM controller and turns its error and status pulses into notification levels for the rest of the system. Five pulses come from the controller: uncorrectable write (poisoned data stored), uncorrectable demand read, uncorrectable scrubber error, correctable read and memory test complete. A sixth event, threshold detect, is made inside the block. A counter of single- and double-bit errors raises it once the count goes above a programmable limit.

Each event sets a sticky status bit that software clears by writing one. Four notification lines each have their own six-bit enable mask, so software can route every event to any set of lines independently of the other events. Each line is a registered level: the OR of the status bits that its mask enables. A global flag reports every pending event in the non-fatal class. A separate local flag marks the three uncorrectable events as fatal.

Top module: `mem_err_router`

## Requirements
- R1: While `rst` is high, all four lines, `sts`, `cnt`, `gerr_nonfatal` and `loc_fatal` are 0 at the next clock edge.
- R2: A pulse on an event input sets its status bit at the next edge, and the bit stays set until it is cleared. The bit positions, used by `sts`, `sts_clr` and all masks, are: 0 uncorrectable write, 1 uncorrectable read, 2 uncorrectable scrubber, 3 correctable read, 4 threshold detect, 5 test complete.
- R3: Each line is registered one edge after `sts` and equals the OR over all bits of (`sts` AND that line's mask). The four lines are independent of each other.
- R4: A one in `sts_clr` clears that status bit at the next edge. Bits written with zero keep their value, and clearing a bit that is already clear has no effect.
- R5: When an event and a clear of the same bit arrive in the same cycle, the event wins and the bit stays set.
- R6: `cnt` increases by one at each edge where any of uncorrectable read, uncorrectable scrubber or correctable read is pulsed. Uncorrectable write and test complete do not count. `cnt_clr` sets `cnt` to 0 and wins over a same-cycle increment.
- R7: `cnt` saturates at 2^CNT_W-1 and never wraps.
- R8: When `cnt` is greater than `cnt_limit`, the block raises an internal one-cycle threshold event, and status bit 4 is set two edges after `cnt` first goes above the limit. It fires once per crossing and rearms only after `cnt_clr`.
- R9: `gerr_nonfatal` is 1 one edge after any status bit is set. `loc_fatal` is 1 one edge after any of bits 0 to 2 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_uc_wr | input | 1 | Pulse: uncorrectable (poisoned) write |
| ev_uc_rd | input | 1 | Pulse: uncorrectable demand read |
| ev_uc_scrub | input | 1 | Pulse: uncorrectable scrubber error |
| ev_cor_rd | input | 1 | Pulse: corrected read error |
| ev_test_done | input | 1 | Pulse: memory test finished |
| route_acpi | input | 6 | Event enable mask for the ACPI notification line |
| route_mgmt | input | 6 | Event enable mask for the management interrupt line |
| route_syserr | input | 6 | Event enable mask for the system error line |
| route_mcheck | input | 6 | Event enable mask for the machine check line |
| cnt_limit | input | CNT_W | Error count threshold |
| sts_clr | input | 6 | Write-one-to-clear strobe per status bit |
| cnt_clr | input | 1 | Clear counter and rearm threshold |
| ntf_acpi | output | 1 | ACPI notification level |
| ntf_mgmt | output | 1 | Management interrupt level |
| ntf_syserr | output | 1 | System error level |
| ntf_mcheck | output | 1 | Machine check level |
| sts | output | 6 | Sticky event status |
| cnt | output | CNT_W | Error count |
| gerr_nonfatal | output | 1 | Global flag: some event pending (non-fatal class) |
| loc_fatal | output | 1 | Some uncorrectable event pending |

## Verification
The assertions check on every cycle that status bits stay set and that an event beats a same-cycle clear. They also check that a clear removes a bit, that a line stays low when nothing enabled in its mask is pending, that the counter moves by at most one and holds at its maximum, that the threshold pulse lasts one cycle, and that the fatal flag implies the global flag. Only the bench scenarios can show the exact latency from each event to each line under different masks, and which inputs count. They also show that the threshold fires once per crossing and rearms after a counter clear, that a clear wins over an increment, and that the counter saturates after a long run.

// File: rtl/mer_pkg.sv
`timescale 1ns/1ps
package mer_pkg;
  localparam int NUM_EV    = 6;
  localparam int NUM_LINES = 4;

  localparam int EV_UC_WR     = 0;
  localparam int EV_UC_RD     = 1;
  localparam int EV_UC_SCRUB  = 2;
  localparam int EV_COR_RD    = 3;
  localparam int EV_THRESH    = 4;
  localparam int EV_TEST_DONE = 5;

  typedef logic [NUM_EV-1:0] ev_vec_t;

  // Locally fatal events: the three uncorrectable ones.
  localparam ev_vec_t FATAL_SET = ev_vec_t'(6'b000111);
endpackage

// File: rtl/mer_err_counter.sv
`timescale 1ns/1ps
module mer_err_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             fire_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic             fired_q;
  logic             fire_q;
  logic             over_w;

  assign over_w = (cnt_q > limit_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      fired_q <= 1'b0;
      fire_q  <= 1'b0;
    end else if (clr_i) begin
      cnt_q   <= '0;
      fired_q <= 1'b0;
      fire_q  <= 1'b0;
    end else begin
      if (inc_i && (cnt_q != CNT_MAX)) begin
        cnt_q <= cnt_q + 1'b1;
      end
      fire_q <= over_w && !fired_q;
      if (over_w) begin
        fired_q <= 1'b1;
      end
    end
  end

  assign cnt_o  = cnt_q;
  assign fire_o = fire_q;

  AST_CNT_SAT: assert property (@(posedge clk) disable iff (rst) (cnt_q == CNT_MAX && !clr_i) |=> (cnt_q == CNT_MAX)); // R7
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst) !clr_i |=> (cnt_q == $past(cnt_q) || cnt_q == CNT_W'($past(cnt_q) + 1'b1))); // R6
  AST_FIRE_ONCE: assert property (@(posedge clk) disable iff (rst) fire_q |=> !fire_q); // R8
endmodule

// File: rtl/mer_sticky.sv
`timescale 1ns/1ps
module mer_sticky #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] sts_o
);
  logic [N-1:0] sts_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sts_q <= '0;
    end else begin
      sts_q <= set_i | (sts_q & ~clr_i);
    end
  end

  assign sts_o = sts_q;

  for (genvar i = 0; i < N; i++) begin : g_chk
    AST_EVT_WINS: assert property (@(posedge clk) disable iff (rst) set_i[i] |=> sts_q[i]); // R5
    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst) (sts_q[i] && !clr_i[i]) |=> sts_q[i]); // R2
    AST_W1C_CLEAR: assert property (@(posedge clk) disable iff (rst) (clr_i[i] && !set_i[i]) |=> !sts_q[i]); // R4
  end
endmodule

// File: rtl/mer_line.sv
`timescale 1ns/1ps
module mer_line #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] sts_i,
  input  logic [N-1:0] mask_i,
  output logic         line_o
);
  logic line_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q <= 1'b0;
    end else begin
      line_q <= |(sts_i & mask_i);
    end
  end

  assign line_o = line_q;

  AST_LINE_QUIET: assert property (@(posedge clk) disable iff (rst) ((sts_i & mask_i) == '0) |=> !line_o); // R3
endmodule

// File: rtl/mem_err_router.sv
`timescale 1ns/1ps
module mem_err_router
  import mer_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_uc_wr,
  input  logic              ev_uc_rd,
  input  logic              ev_uc_scrub,
  input  logic              ev_cor_rd,
  input  logic              ev_test_done,
  input  logic [NUM_EV-1:0] route_acpi,
  input  logic [NUM_EV-1:0] route_mgmt,
  input  logic [NUM_EV-1:0] route_syserr,
  input  logic [NUM_EV-1:0] route_mcheck,
  input  logic [CNT_W-1:0]  cnt_limit,
  input  logic [NUM_EV-1:0] sts_clr,
  input  logic              cnt_clr,
  output logic              ntf_acpi,
  output logic              ntf_mgmt,
  output logic              ntf_syserr,
  output logic              ntf_mcheck,
  output logic [NUM_EV-1:0] sts,
  output logic [CNT_W-1:0]  cnt,
  output logic              gerr_nonfatal,
  output logic              loc_fatal
);
  ev_vec_t              ev_set;
  ev_vec_t              sts_w;
  ev_vec_t              masks [NUM_LINES];
  logic [NUM_LINES-1:0] lines_w;
  logic                 thr_fire;
  logic                 cnt_inc;
  logic                 gerr_q;
  logic                 fatal_q;

  // Single- and double-bit error sources feed the counter.
  assign cnt_inc = ev_uc_rd | ev_uc_scrub | ev_cor_rd;

  mer_err_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .inc_i   (cnt_inc),
    .clr_i   (cnt_clr),
    .limit_i (cnt_limit),
    .cnt_o   (cnt),
    .fire_o  (thr_fire)
  );

  always_comb begin
    ev_set               = '0;
    ev_set[EV_UC_WR]     = ev_uc_wr;
    ev_set[EV_UC_RD]     = ev_uc_rd;
    ev_set[EV_UC_SCRUB]  = ev_uc_scrub;
    ev_set[EV_COR_RD]    = ev_cor_rd;
    ev_set[EV_THRESH]    = thr_fire;
    ev_set[EV_TEST_DONE] = ev_test_done;
  end

  mer_sticky #(.N(NUM_EV)) u_sts (
    .clk   (clk),
    .rst   (rst),
    .set_i (ev_set),
    .clr_i (sts_clr),
    .sts_o (sts_w)
  );

  assign masks[0] = route_acpi;
  assign masks[1] = route_mgmt;
  assign masks[2] = route_syserr;
  assign masks[3] = route_mcheck;

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    mer_line #(.N(NUM_EV)) u_line (
      .clk    (clk),
      .rst    (rst),
      .sts_i  (sts_w),
      .mask_i (masks[l]),
      .line_o (lines_w[l])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gerr_q  <= 1'b0;
      fatal_q <= 1'b0;
    end else begin
      gerr_q  <= |sts_w;
      fatal_q <= |(sts_w & FATAL_SET);
    end
  end

  assign ntf_acpi      = lines_w[0];
  assign ntf_mgmt      = lines_w[1];
  assign ntf_syserr    = lines_w[2];
  assign ntf_mcheck    = lines_w[3];
  assign sts           = sts_w;
  assign gerr_nonfatal = gerr_q;
  assign loc_fatal     = fatal_q;

  AST_FATAL_IN_GLOBAL: assert property (@(posedge clk) disable iff (rst) loc_fatal |-> gerr_nonfatal); // R9
  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (lines_w == '0 && sts_w == '0)); // R1
endmodule

// File: tb/mem_err_router_test.sv
`timescale 1ns/1ps
module mem_err_router_test;
  localparam int CW = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst;
  logic [5:0]    evs;
  logic [5:0]    m_acpi, m_mgmt, m_sys, m_mck;
  logic [CW-1:0] limit;
  logic [5:0]    sclr;
  logic          cclr;
  logic          o_acpi, o_mgmt, o_sys, o_mck, o_gerr, o_fatal;
  logic [5:0]    o_sts;
  logic [CW-1:0] o_cnt;

  mem_err_router #(.CNT_W(CW)) uut (
    .clk(clk), .rst(rst),
    .ev_uc_wr(evs[0]), .ev_uc_rd(evs[1]), .ev_uc_scrub(evs[2]),
    .ev_cor_rd(evs[3]), .ev_test_done(evs[5]),
    .route_acpi(m_acpi), .route_mgmt(m_mgmt), .route_syserr(m_sys), .route_mcheck(m_mck),
    .cnt_limit(limit), .sts_clr(sclr), .cnt_clr(cclr),
    .ntf_acpi(o_acpi), .ntf_mgmt(o_mgmt), .ntf_syserr(o_sys), .ntf_mcheck(o_mck),
    .sts(o_sts), .cnt(o_cnt), .gerr_nonfatal(o_gerr), .loc_fatal(o_fatal)
  );

  typedef struct {
    int          cyc;
    int          sel;
    logic [31:0] val;
    string       tag;
  } exp_t;

  exp_t sbq[$];
  int   cyc = 0;
  int   n_chk = 0;
  int   n_fail = 0;

  always @(posedge clk) cyc++;

  // sel: 0 acpi, 1 mgmt, 2 syserr, 3 mcheck, 4 sts, 5 cnt, 6 gerr, 7 fatal
  function automatic logic [31:0] probe(int sel);
    case (sel)
      0: return 32'(o_acpi);
      1: return 32'(o_mgmt);
      2: return 32'(o_sys);
      3: return 32'(o_mck);
      4: return 32'(o_sts);
      5: return 32'(o_cnt);
      6: return 32'(o_gerr);
      default: return 32'(o_fatal);
    endcase
  endfunction

  // Monitor: pops expectations due this cycle and compares.
  always @(negedge clk) begin
    for (int i = sbq.size() - 1; i >= 0; i--) begin
      if (sbq[i].cyc == cyc) begin
        logic [31:0] act;
        act = probe(sbq[i].sel);
        n_chk++;
        if (act !== sbq[i].val) begin
          n_fail++;
          $display("FAIL %s sel=%0d cycle=%0d actual=%0h expected=%0h",
                   sbq[i].tag, sbq[i].sel, cyc, act, sbq[i].val);
        end
        sbq.delete(i);
      end
    end
  end

  task automatic expect_at(int dly, int sel, logic [31:0] v, string tag);
    exp_t e;
    e.cyc = cyc + dly;
    e.sel = sel;
    e.val = v;
    e.tag = tag;
    sbq.push_back(e);
  endtask

  task automatic drive(logic [5:0] e, logic [5:0] c, logic cc);
    @(negedge clk);
    #1;
    evs  = e;
    sclr = c;
    cclr = cc;
  endtask

  task automatic idle(int n);
    repeat (n) drive(6'b0, 6'b0, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; evs = '0; sclr = '0; cclr = 1'b0; limit = '1;
    m_acpi = '0; m_mgmt = '0; m_sys = '0; m_mck = '0;
    idle(2);
    // R1: reset state
    for (int s = 0; s < 8; s++) expect_at(1, s, 32'd0, "R1");
    idle(2);
    @(negedge clk); #1; rst = 1'b0;

    // R2/R3/R9: one event routed by masks
    m_acpi = 6'b000001; m_mgmt = 6'b000010; m_sys = 6'b100000; m_mck = 6'b000111;
    idle(1);
    drive(6'b000001, 6'b0, 1'b0);
    expect_at(1, 4, 32'h01, "R2");
    expect_at(2, 0, 32'd1, "R3");
    expect_at(2, 1, 32'd0, "R3");
    expect_at(2, 2, 32'd0, "R3");
    expect_at(2, 3, 32'd1, "R3");
    expect_at(2, 6, 32'd1, "R9");
    expect_at(2, 7, 32'd1, "R9");
    idle(3);
    expect_at(1, 4, 32'h01, "R2");

    // R4: clear, then clear of already-clear bits
    drive(6'b0, 6'b000001, 1'b0);
    expect_at(1, 4, 32'h00, "R4");
    expect_at(2, 0, 32'd0, "R4");
    expect_at(2, 3, 32'd0, "R4");
    expect_at(2, 6, 32'd0, "R9");
    drive(6'b0, 6'b111111, 1'b0);
    expect_at(1, 4, 32'h00, "R4");
    idle(2);

    // R9/R6: test complete is non-fatal and not counted
    drive(6'b100000, 6'b0, 1'b0);
    expect_at(1, 4, 32'h20, "R2");
    expect_at(1, 5, 32'd0, "R6");
    expect_at(2, 2, 32'd1, "R3");
    expect_at(2, 0, 32'd0, "R3");
    expect_at(2, 6, 32'd1, "R9");
    expect_at(2, 7, 32'd0, "R9");
    idle(1);

    // R5: event and clear on same bit; R4: clear other bit keeps event
    drive(6'b100000, 6'b100000, 1'b0);
    expect_at(1, 4, 32'h20, "R5");
    drive(6'b000010, 6'b100000, 1'b0);
    expect_at(1, 4, 32'h02, "R4");
    expect_at(1, 5, 32'd1, "R6");
    expect_at(2, 1, 32'd1, "R3");
    expect_at(2, 2, 32'd0, "R3");
    drive(6'b0, 6'b111111, 1'b1);
    expect_at(1, 4, 32'h00, "R4");
    expect_at(1, 5, 32'd0, "R6");
    idle(2);

    // R8: threshold crossing with limit 2
    limit = 8'd2;
    m_acpi = 6'b010000;
    idle(1);
    drive(6'b001000, 6'b0, 1'b0);
    expect_at(1, 5, 32'd1, "R6");
    drive(6'b001000, 6'b0, 1'b0);
    expect_at(1, 5, 32'd2, "R6");
    drive(6'b001000, 6'b0, 1'b0);
    expect_at(1, 5, 32'd3, "R6");
    expect_at(2, 4, 32'h08, "R8");
    expect_at(3, 4, 32'h18, "R8");
    expect_at(3, 0, 32'd0, "R8");
    expect_at(4, 0, 32'd1, "R8");
    idle(5);
    drive(6'b0, 6'b111111, 1'b0);
    idle(1);
    // Further counting must not fire again
    drive(6'b001000, 6'b0, 1'b0);
    expect_at(1, 5, 32'd4, "R6");
    expect_at(4, 4, 32'h08, "R8");
    expect_at(5, 0, 32'd0, "R8");
    idle(6);
    // R6: counter clear wins over increment
    drive(6'b001000, 6'b111111, 1'b1);
    expect_at(1, 5, 32'd0, "R6");
    expect_at(1, 4, 32'h08, "R5");
    drive(6'b0, 6'b111111, 1'b0);
    // Rearmed: three counted sources cross again
    drive(6'b000100, 6'b0, 1'b0);
    drive(6'b000010, 6'b0, 1'b0);
    drive(6'b001000, 6'b0, 1'b0);
    expect_at(1, 5, 32'd3, "R6");
    expect_at(3, 4, 32'h1E, "R8");
    expect_at(4, 0, 32'd1, "R8");
    idle(6);

    // R7: saturation, limit at max never fires
    limit = '1;
    drive(6'b0, 6'b111111, 1'b1);
    for (int k = 0; k < 260; k++) begin
      drive(6'b001000, 6'b0, 1'b0);
      if (k == 254) expect_at(1, 5, 32'd255, "R7");
      if (k == 255) expect_at(1, 5, 32'd255, "R7");
    end
    expect_at(1, 5, 32'd255, "R7");
    expect_at(3, 4, 32'h08, "R8");
    idle(6);

    if (sbq.size() != 0) begin
      n_chk++;
      n_fail++;
      $display("FAIL scoreboard R1 actual=%0d expected=0 pending items", sbq.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule